// File: doc/BRIEF.md
# Store Gathering Write Combiner

This block sits between the head of a pending-store queue and a 64-bit system bus. Every cycle it looks at the oldest queued store (the head) and, when one is present, the store behind it (the lookahead). When gathering is switched on and both entries are word stores to the two halves of the same doubleword, it issues them together as one single-beat doubleword write with all eight byte lanes enabled. In every other case the head goes out alone with only its own byte lanes enabled.

The block never holds a store back to wait for a partner. A pair is combined only if both stores are already in the queue. The choice between a paired and a single write is made when the request is first raised, and it then stays fixed until the bus accepts. A lookahead that turns up during that wait, or a change of the enable, cannot alter the request on the bus. Byte-lane placement follows a selectable endian mode. Gathering works for both address orders of the pair and in both endian modes.

Top module: `stg_combiner`

## Requirements
- R1: With `gather_en` low when a request is first raised, the head store is issued alone and `nx_pop` stays low.
- R2: A store can be gathered only if `*_size` is 4 (the size field gives a byte count: 1, 2 or 4) and address bits [1:0] are zero.
- R3: A store can be gathered only if its guarded bit is clear and at least one of its write-through and cache-inhibited bits is set.
- R4: A gathered pair is issued as one request with `bus_addr` set to the doubleword address (bits [2:0] zero), `bus_be` equal to 8'hFF, `bus_beats` equal to 1, and both words placed in their byte lanes.
- R5: Two eligible stores are gathered only if their addresses agree above bit 2 and differ in bit 2. This holds whichever of the two has the lower address. Two stores to the same word are never gathered.
- R6: `bus_req` is high in every cycle in which `hd_valid` is high, whether or not a lookahead is present.
- R7: A store that is issued alone uses `bus_addr` equal to its own address and `bus_beats` equal to 1. With `big_endian` low, the byte at address offset o (address bits [2:0]) uses lane o, and data byte i of the store goes to offset o+i. With `big_endian` high, offset o uses lane 7-o, and data byte i goes to offset o+size-1-i. Lane k is `bus_data[8k+7:8k]` and is enabled by `bus_be[k]`. Stores never cross a doubleword boundary.
- R8: `hd_pop` is high exactly when `bus_req` and `bus_ack` are both high. `nx_pop` is high only together with `hd_pop`, and only for a gathered pair.
- R9: While a request waits without `bus_ack`, in the next cycle the request stays up with the same address, data, byte enables and pairing choice. This holds even if the lookahead appears or `gather_en` changes.
- R10: With `hd_valid` low, `bus_req`, `hd_pop` and `nx_pop` are all low, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gather_en | input | 1 | Allows pairing of eligible stores |
| big_endian | input | 1 | Byte-lane ordering mode |
| hd_valid | input | 1 | Head store present |
| hd_addr | input | AW | Head store byte address |
| hd_data | input | 32 | Head store data, right-justified |
| hd_size | input | 3 | Head store byte count (1, 2, 4) |
| hd_wt | input | 1 | Head write-through attribute |
| hd_ci | input | 1 | Head cache-inhibited attribute |
| hd_grd | input | 1 | Head guarded attribute |
| nx_valid | input | 1 | Lookahead store present |
| nx_addr | input | AW | Lookahead store byte address |
| nx_data | input | 32 | Lookahead store data |
| nx_size | input | 3 | Lookahead byte count |
| nx_wt | input | 1 | Lookahead write-through attribute |
| nx_ci | input | 1 | Lookahead cache-inhibited attribute |
| nx_grd | input | 1 | Lookahead guarded attribute |
| bus_ack | input | 1 | Bus accepts the current request |
| bus_req | output | 1 | Write request valid |
| bus_addr | output | AW | Write address |
| bus_data | output | 64 | Write data by byte lane |
| bus_be | output | 8 | Byte-lane enables |
| bus_beats | output | BEAT_W | Beat count, always one |
| hd_pop | output | 1 | Dequeue head this cycle |
| nx_pop | output | 1 | Dequeue lookahead this cycle |

## Verification
Several things can happen in the same cycle: a lookahead can arrive, the enable can flip, or the endian mode can be in use while an earlier request is still waiting for the bus. In that cycle the frozen pairing choice must win over the choice that the new inputs alone would give. The bench provokes this with a phase in which acceptance is rare, the enable toggles at random and lookahead entries become visible partway through a wait. The bench model keeps its own record of the pending choice, and every output is compared against it each cycle. Dequeue and pairing can also coincide: `hd_pop` and `nx_pop` in one cycle. A wrong count of entries removed shows up at once, because the model's queue and the design's view of the head and lookahead drift apart.

// File: rtl/stg_pkg.sv
package stg_pkg;
   localparam int BUS_BYTES  = 8;
   localparam int WORD_BYTES = 4;
   localparam int LANE_IDX_W = $clog2(BUS_BYTES);

   typedef struct packed {
      logic [BUS_BYTES-1:0]   be;
      logic [8*BUS_BYTES-1:0] data;
   } lane_t;
endpackage

// File: rtl/stg_elig.sv
module stg_elig
   import stg_pkg::*;
(
   input  logic [1:0] addr_lo,
   input  logic [2:0] size,
   input  logic       wt,
   input  logic       ci,
   input  logic       grd,
   output logic       ok
);
   always_comb begin
      ok = (size == 3'(WORD_BYTES)) && (addr_lo == 2'b00) && !grd && (wt || ci);
   end
endmodule

// File: rtl/stg_lane.sv
module stg_lane
   import stg_pkg::*;
(
   input  logic [2:0]  off,
   input  logic [2:0]  size,
   input  logic [31:0] data,
   input  logic        big_end,
   output lane_t       lane
);
   logic [3:0]  mask4;
   logic [3:0]  sh;
   logic [31:0] dmask;
   logic [63:0] wide;

   always_comb begin
      unique case (size)
         3'd1:    mask4 = 4'b0001;
         3'd2:    mask4 = 4'b0011;
         3'd4:    mask4 = 4'b1111;
         default: mask4 = 4'b0000;
      endcase
      sh    = big_end ? (4'd8 - {1'b0, off} - {1'b0, size}) : {1'b0, off};
      dmask = {{8{mask4[3]}}, {8{mask4[2]}}, {8{mask4[1]}}, {8{mask4[0]}}};
      wide  = {32'b0, data & dmask};
      lane.be   = {4'b0, mask4} << sh;
      lane.data = wide << {sh, 3'b000};
   end
endmodule

// File: rtl/stg_combiner.sv
module stg_combiner
   import stg_pkg::*;
#(
   parameter int AW     = 32,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gather_en,
   input  logic              big_endian,
   input  logic              hd_valid,
   input  logic [AW-1:0]     hd_addr,
   input  logic [31:0]       hd_data,
   input  logic [2:0]        hd_size,
   input  logic              hd_wt,
   input  logic              hd_ci,
   input  logic              hd_grd,
   input  logic              nx_valid,
   input  logic [AW-1:0]     nx_addr,
   input  logic [31:0]       nx_data,
   input  logic [2:0]        nx_size,
   input  logic              nx_wt,
   input  logic              nx_ci,
   input  logic              nx_grd,
   input  logic              bus_ack,
   output logic              bus_req,
   output logic [AW-1:0]     bus_addr,
   output logic [63:0]       bus_data,
   output logic [7:0]        bus_be,
   output logic [BEAT_W-1:0] bus_beats,
   output logic              hd_pop,
   output logic              nx_pop
);
   localparam int NSLOT = 2;

   if (AW < LANE_IDX_W + 1) begin : g_bad_aw
      $error("stg_combiner: AW too small for doubleword addressing");
   end
   if (BEAT_W < 1) begin : g_bad_beat
      $error("stg_combiner: BEAT_W must be at least 1");
   end

   logic [NSLOT-1:0][AW-1:0] s_addr;
   logic [NSLOT-1:0][31:0]   s_data;
   logic [NSLOT-1:0][2:0]    s_size;
   logic [NSLOT-1:0]         s_wt, s_ci, s_grd, s_ok;
   lane_t                    s_lane [NSLOT];

   assign s_addr = {nx_addr, hd_addr};
   assign s_data = {nx_data, hd_data};
   assign s_size = {nx_size, hd_size};
   assign s_wt   = {nx_wt, hd_wt};
   assign s_ci   = {nx_ci, hd_ci};
   assign s_grd  = {nx_grd, hd_grd};

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      stg_elig u_elig (
         .addr_lo (s_addr[g][1:0]),
         .size    (s_size[g]),
         .wt      (s_wt[g]),
         .ci      (s_ci[g]),
         .grd     (s_grd[g]),
         .ok      (s_ok[g])
      );
      stg_lane u_lane (
         .off     (s_addr[g][LANE_IDX_W-1:0]),
         .size    (s_size[g]),
         .data    (s_data[g]),
         .big_end (big_endian),
         .lane    (s_lane[g])
      );
   end

   logic pend_q, held_q;
   logic same_dw, diff_word, pair_live, pair_sel;

   always_comb begin
      same_dw   = hd_addr[AW-1:LANE_IDX_W] == nx_addr[AW-1:LANE_IDX_W];
      diff_word = hd_addr[2] != nx_addr[2];
      pair_live = gather_en && hd_valid && nx_valid && (&s_ok) && same_dw && diff_word;
      pair_sel  = pend_q ? held_q : pair_live;
   end

   always_comb begin
      bus_req   = hd_valid;
      bus_beats = BEAT_W'(1);
      if (pair_sel) begin
         bus_addr = {hd_addr[AW-1:LANE_IDX_W], {LANE_IDX_W{1'b0}}};
         bus_data = s_lane[0].data | s_lane[1].data;
         bus_be   = s_lane[0].be | s_lane[1].be;
      end else begin
         bus_addr = hd_addr;
         bus_data = s_lane[0].data;
         bus_be   = s_lane[0].be;
      end
      hd_pop = hd_valid && bus_ack;
      nx_pop = hd_pop && pair_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         held_q <= 1'b0;
      end else begin
         pend_q <= hd_valid && !bus_ack;
         held_q <= pair_sel;
      end
   end
endmodule

// File: rtl/stg_combiner_chk.sv
module stg_combiner_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hd_valid,
   input logic [AW-1:0] hd_addr,
   input logic [2:0]    hd_size,
   input logic          hd_wt,
   input logic          hd_ci,
   input logic          hd_grd,
   input logic [AW-1:0] nx_addr,
   input logic [2:0]    nx_size,
   input logic          nx_wt,
   input logic          nx_ci,
   input logic          nx_grd,
   input logic          bus_ack,
   input logic          bus_req,
   input logic [AW-1:0] bus_addr,
   input logic [63:0]   bus_data,
   input logic [7:0]    bus_be,
   input logic          hd_pop,
   input logic          nx_pop
);
   AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_data) && $stable(bus_be) && $stable(hd_addr))) else $error("AST_REQ_FROZEN"); // R9
   AST_POP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      hd_pop |-> (bus_req && bus_ack)) else $error("AST_POP_ON_ACK"); // R8
   AST_PAIR_POP: assert property (@(posedge clk) disable iff (!rst_n)
      nx_pop |-> (hd_pop && bus_be == 8'hFF && bus_addr[2:0] == 3'b000)) else $error("AST_PAIR_POP"); // R4
   AST_PAIR_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
      nx_pop |-> (hd_size == 3'd4 && nx_size == 3'd4 && hd_addr[1:0] == 2'b00 && nx_addr[1:0] == 2'b00)) else $error("AST_PAIR_ELIG"); // R2
   AST_PAIR_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
      nx_pop |-> (!hd_grd && !nx_grd && (hd_wt || hd_ci) && (nx_wt || nx_ci))) else $error("AST_PAIR_ATTR"); // R3
   AST_PAIR_DW: assert property (@(posedge clk) disable iff (!rst_n)
      nx_pop |-> (hd_addr[AW-1:3] == nx_addr[AW-1:3] && hd_addr[2] != nx_addr[2])) else $error("AST_PAIR_DW"); // R5
   AST_ISSUE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      hd_valid |-> bus_req) else $error("AST_ISSUE_HEAD"); // R6
   AST_SINGLE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_be != 8'hFF) |-> ($countones(bus_be) == 32'(hd_size))) else $error("AST_SINGLE_LANES"); // R7
   AST_IDLE: assert property (@(posedge clk)
      !hd_valid |-> (!bus_req && !hd_pop && !nx_pop)) else $error("AST_IDLE"); // R10
endmodule

bind stg_combiner stg_combiner_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .hd_valid(hd_valid), .hd_addr(hd_addr), .hd_size(hd_size),
   .hd_wt(hd_wt), .hd_ci(hd_ci), .hd_grd(hd_grd), .nx_addr(nx_addr), .nx_size(nx_size),
   .nx_wt(nx_wt), .nx_ci(nx_ci), .nx_grd(nx_grd), .bus_ack(bus_ack), .bus_req(bus_req),
   .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be), .hd_pop(hd_pop), .nx_pop(nx_pop)
);

// File: tb/tb_stg_combiner.sv
module tb_stg_combiner;
   localparam int AW = 32;
   localparam int PH_CYC = 1500;
   localparam int WD_LIMIT = 200000;

   typedef struct {
      logic [AW-1:0] addr;
      logic [31:0]   data;
      logic [2:0]    size;
      logic          wt, ci, grd;
   } st_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gather_en = 1'b0, big_endian = 1'b0;
   logic hd_valid = 1'b0, nx_valid = 1'b0, bus_ack = 1'b0;
   logic [AW-1:0] hd_addr = '0, nx_addr = '0;
   logic [31:0] hd_data = '0, nx_data = '0;
   logic [2:0] hd_size = '0, nx_size = '0;
   logic hd_wt = 1'b0, hd_ci = 1'b0, hd_grd = 1'b0;
   logic nx_wt = 1'b0, nx_ci = 1'b0, nx_grd = 1'b0;
   logic bus_req, hd_pop, nx_pop;
   logic [AW-1:0] bus_addr;
   logic [63:0] bus_data;
   logic [7:0] bus_be;
   logic [1:0] bus_beats;

   always #5 clk = ~clk;

   stg_combiner #(.AW(AW), .BEAT_W(2)) dut (
      .clk(clk), .rst_n(rst_n), .gather_en(gather_en), .big_endian(big_endian),
      .hd_valid(hd_valid), .hd_addr(hd_addr), .hd_data(hd_data), .hd_size(hd_size),
      .hd_wt(hd_wt), .hd_ci(hd_ci), .hd_grd(hd_grd),
      .nx_valid(nx_valid), .nx_addr(nx_addr), .nx_data(nx_data), .nx_size(nx_size),
      .nx_wt(nx_wt), .nx_ci(nx_ci), .nx_grd(nx_grd), .bus_ack(bus_ack),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data), .bus_be(bus_be),
      .bus_beats(bus_beats), .hd_pop(hd_pop), .nx_pop(nx_pop)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 0;
   string tag = "R10";
   st_t q[$];
   bit nx_vis = 0;
   bit m_pend = 0, m_held = 0;
   bit pop_h = 0, pop_n = 0;

   task automatic cmp(string sig, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, sig, act, exp);
      end
   endtask

   function automatic bit elig(st_t s);
      return s.size == 3'd4 && s.addr[1:0] == 2'b00 && !s.grd && (s.wt || s.ci);
   endfunction

   // byte placement written from the addressing rule of R7
   function automatic void place(st_t s, bit be_mode, output logic [63:0] d, output logic [7:0] e);
      d = '0; e = '0;
      for (int i = 0; i < int'(s.size); i++) begin
         int o = int'(s.addr[2:0]) + i;
         int src = be_mode ? (int'(s.size) - 1 - i) : i;
         int lane = be_mode ? 7 - o : o;
         d[8*lane +: 8] = s.data[8*src +: 8];
         e[lane] = 1'b1;
      end
   endfunction

   function automatic st_t make_store(int ph);
      st_t s;
      int dw = (ph == 4) ? $urandom_range(0, 1) : $urandom_range(0, 3);
      int w = $urandom_range(0, 1);
      int off = w * 4;
      s.data = $urandom;
      s.size = 3'd4;
      s.wt = 1'($urandom_range(0, 1));
      s.ci = s.wt ? 1'($urandom_range(0, 1)) : 1'b1;
      s.grd = 1'b0;
      if (ph == 1 || ph == 6) begin
         case ($urandom_range(0, 3))
            0: begin s.size = 3'd1; off = $urandom_range(0, 7); end
            1: begin s.size = 3'd2; off = 2 * $urandom_range(0, 3); end
            2: begin s.size = 3'd4; off = 2; end
            default: ;
         endcase
      end
      if (ph == 2) begin
         s.grd = ($urandom_range(0, 3) == 0);
         s.wt = 1'($urandom_range(0, 1));
         s.ci = 1'($urandom_range(0, 1));
      end
      s.addr = 32'h2000_0040 + AW'(dw * 8 + off);
      return s;
   endfunction

   task automatic drive();
      hd_valid = q.size() > 0;
      nx_valid = q.size() > 1 && nx_vis;
      if (q.size() > 0) begin
         hd_addr = q[0].addr; hd_data = q[0].data; hd_size = q[0].size;
         hd_wt = q[0].wt; hd_ci = q[0].ci; hd_grd = q[0].grd;
      end
      if (q.size() > 1) begin
         nx_addr = q[1].addr; nx_data = q[1].data; nx_size = q[1].size;
         nx_wt = q[1].wt; nx_ci = q[1].ci; nx_grd = q[1].grd;
      end
   endtask

   task automatic model_check();
      logic [63:0] ed, d1;
      logic [7:0]  ee, e1;
      logic [AW-1:0] ea;
      bit live, merge;
      bit hv = q.size() > 0;
      bit nv = q.size() > 1 && nx_vis;
      live = gather_en && hv && nv && elig(q[0]) && elig(q[1])
             && q[0].addr[AW-1:3] == q[1].addr[AW-1:3] && q[0].addr[2] != q[1].addr[2];
      merge = m_pend ? m_held : live;
      cmp("bus_req", 64'(bus_req), 64'(hv));
      cmp("hd_pop", 64'(hd_pop), 64'(hv && bus_ack));
      cmp("nx_pop", 64'(nx_pop), 64'(hv && bus_ack && merge));
      if (hv) begin
         place(q[0], big_endian, ed, ee);
         ea = q[0].addr;
         if (merge) begin
            place(q[1], big_endian, d1, e1);
            ed = ed | d1; ee = ee | e1;
            ea = {q[0].addr[AW-1:3], 3'b000};
         end
         cmp("bus_addr", 64'(bus_addr), 64'(ea));
         cmp("bus_data", bus_data, ed);
         cmp("bus_be", 64'(bus_be), 64'(ee));
         cmp("bus_beats", 64'(bus_beats), 64'd1);
      end
      pop_h = hv && bus_ack;
      pop_n = pop_h && merge;
      m_pend = hv && !bus_ack;
      m_held = merge;
   endtask

   initial begin
      #(WD_LIMIT * 10);
      if (!done) begin
         fails++;
         $display("FAIL R6 watchdog: actual not finished expected finished in %0d cycles", WD_LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      string tags[9] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8", "R9"};
      tag = "R10";
      repeat (3) begin
         @(negedge clk);
         model_check();
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      m_pend = 0; m_held = 0; pop_h = 0; pop_n = 0;
      for (int ph = 0; ph < 9; ph++) begin
         tag = tags[ph];
         for (int c = 0; c < PH_CYC; c++) begin
            @(posedge clk); #1;
            if (pop_h) void'(q.pop_front());
            if (pop_n) void'(q.pop_front());
            if (pop_h) nx_vis = ($urandom_range(0, 1) == 1);
            if (!nx_vis && $urandom_range(0, 9) < ((ph == 5) ? 1 : 3)) nx_vis = 1;
            if (q.size() < 3 && $urandom_range(0, 9) < 7) q.push_back(make_store(ph));
            if (q.size() < 3 && $urandom_range(0, 9) < 4) q.push_back(make_store(ph));
            gather_en = (ph == 0) ? 1'b0 : (ph == 8) ? 1'($urandom_range(0, 1)) : 1'b1;
            if (!m_pend) begin
               if (ph == 6) big_endian = 1'($urandom_range(0, 1));
               else big_endian = 1'(ph % 2);
            end
            // R10 again whenever the queue drains
            drive();
            bus_ack = ($urandom_range(0, 9) < ((ph == 8) ? 2 : 6));
            @(negedge clk);
            model_check();
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule